// File: doc/BRIEF.md
# Clock Source Select Controller

This controller keeps an 8-bit selection register and uses it to decide which of three sources drives the system clock: the main oscillator clock, a PLL-multiplied clock, or a low-speed sub clock. Software writes a request for a source and a stabilization wait code. The controller holds the current source while a stabilization counter runs. It moves the select output to the new source only when the chosen interval has passed. Two read-only status bits show the source that is actually in use, so software can poll them to see when a switch has finished.

The PLL multiplier code goes out on `pll_mult` to an external PLL. The top bit of that code comes from a separate register and arrives on `mul_msb` at write time. The source choice itself is a registered two-bit select. A downstream glitch-free clock mux acts on it. The controller has two resets. A power-on reset and an ordinary reset restore the same register value. They differ in one respect: after a power-on reset, wait code 11 gives a longer interval than after an ordinary reset.

Top module: `clk_src_ctrl`

## Requirements
- R1: Either reset (`por_n` or `rst_n` low at a clock edge) sets `rdata` to 8'hFC, `clk_sel` to main (2'b00) and `pll_mult` to 3'b000.
- R2: Bits 7 and 6 of `rdata` are status bits and are read-only; a write has no effect on them. Bit 7 reads 0 only while `clk_sel` is sub (2'b10). Bit 6 reads 0 only while `clk_sel` is PLL (2'b01).
- R3: Bit 3 = 0 requests the sub clock. Otherwise, bit 2 = 0 requests the PLL clock. With both bits at 1, the main clock is requested. When both bits are 0, the sub clock wins. Bits 5:2 read back as written.
- R4: A write loads the code {mul_msb, wdata[1:0]} into `pll_mult`, and wdata[1:0] into `rdata[1:0]`, only when the code is 000, 001, 010, 011 or 110. Any other code leaves both unchanged.
- R5: Bits 5:4 select the wait. Code 00 gives 2^EXP_W0 cycles, code 01 gives 2^EXP_W1 cycles and code 10 gives 2^EXP_W2 cycles. Defaults are 10, 13 and 17. After a write that requests a source other than the active one, `clk_sel` and the status bits change exactly that many clock edges after the write edge.
- R6: Code 11 gives 2^EXP_W3 cycles (default 15) when the most recent reset was an ordinary reset. It gives 2^EXP_W3_POR cycles (default 16) when the most recent reset was a power-on reset.
- R7: A write made while a wait is pending restarts the wait from zero. The new wait uses the newest request and the newest wait code.
- R8: A write that requests the source already active cancels any pending wait, and `clk_sel` does not change.
- R9: `clk_sel` never changes on the edge of a write. It stays constant while a wait is counting.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| por_n | input | 1 | Power-on reset, synchronous, active low |
| rst_n | input | 1 | Ordinary reset, synchronous, active low |
| wr_en | input | 1 | Register write strobe |
| wdata | input | 8 | Register write data |
| mul_msb | input | 1 | Top multiplier bit, taken from a separate register |
| rdata | output | 8 | Register read value with status bits |
| pll_mult | output | 3 | Multiplier code sent to the external PLL |
| clk_sel | output | 2 | Active source: 00 main, 01 PLL, 10 sub |

## Verification
The assertions check on every cycle that the select output stays fixed on write edges and during a counting wait. They also check that the select output matches the requested source whenever no wait is pending, that it lands on the requested source when the counter expires, and that the multiplier output never holds a disallowed code. Some behaviour only the bench scenarios can show: the exact wait length for each code, the difference between power-on and ordinary reset for code 11, the restart of a wait on a mid-wait write, the cancel of a wait, and sub-clock priority. The bench shows these by comparing every output, cycle by cycle, against a countdown model.

// File: rtl/clk_src_ctrl.sv
module clk_src_ctrl #(
  parameter int EXP_W0     = 10,
  parameter int EXP_W1     = 13,
  parameter int EXP_W2     = 17,
  parameter int EXP_W3     = 15,
  parameter int EXP_W3_POR = 16
) (
  input  logic       clk,
  input  logic       por_n,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wdata,
  input  logic       mul_msb,
  output logic [7:0] rdata,
  output logic [2:0] pll_mult,
  output logic [1:0] clk_sel
);
  localparam int MA = (EXP_W0 > EXP_W1) ? EXP_W0 : EXP_W1;
  localparam int MB = (EXP_W2 > EXP_W3) ? EXP_W2 : EXP_W3;
  localparam int MC = (MA > MB) ? MA : MB;
  localparam int MAXE = (MC > EXP_W3_POR) ? MC : EXP_W3_POR;
  localparam int CW = MAXE + 1;

  localparam logic [1:0] SEL_MAIN = 2'b00;
  localparam logic [1:0] SEL_PLL  = 2'b01;
  localparam logic [1:0] SEL_SUB  = 2'b10;

  logic [1:0]    ws;
  logic          sub_req_n, pll_req_n;
  logic [2:0]    mul;
  logic [1:0]    act;
  logic          pend;
  logic [CW-1:0] cnt;
  logic [CW-1:0] lim;
  logic          por_last;

  wire any_rst = !por_n || !rst_n;

  function automatic logic [1:0] pick(input logic s_n, input logic p_n);
    if (!s_n)      return SEL_SUB;
    else if (!p_n) return SEL_PLL;
    else           return SEL_MAIN;
  endfunction

  wire [1:0] tgt   = pick(sub_req_n, pll_req_n);
  wire [1:0] tgt_w = pick(wdata[3], wdata[2]);
  wire [2:0] wcode = {mul_msb, wdata[1:0]};
  wire       code_ok = wcode[2] ? (wcode[1:0] == 2'b10) : 1'b1;

  always_comb begin
    case (ws)
      2'b00:   lim = CW'(1) << EXP_W0;
      2'b01:   lim = CW'(1) << EXP_W1;
      2'b10:   lim = CW'(1) << EXP_W2;
      default: lim = por_last ? (CW'(1) << EXP_W3_POR) : (CW'(1) << EXP_W3);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!por_n)      por_last <= 1'b1;
    else if (!rst_n) por_last <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (any_rst) begin
      ws        <= 2'b11;
      sub_req_n <= 1'b1;
      pll_req_n <= 1'b1;
      mul       <= 3'b000;
      act       <= SEL_MAIN;
      pend      <= 1'b0;
      cnt       <= '0;
    end else if (wr_en) begin
      ws        <= wdata[5:4];
      sub_req_n <= wdata[3];
      pll_req_n <= wdata[2];
      if (code_ok) mul <= wcode;
      pend      <= (tgt_w != act);
      cnt       <= '0;
    end else if (pend) begin
      if (cnt == lim - CW'(1)) begin
        act  <= tgt;
        pend <= 1'b0;
        cnt  <= '0;
      end else begin
        cnt <= cnt + CW'(1);
      end
    end
  end

  assign clk_sel  = act;
  assign pll_mult = mul;
  assign rdata    = {act != SEL_SUB, act != SEL_PLL, ws, sub_req_n, pll_req_n, mul[1:0]};

  assert_idle_match_R3: assert property (@(posedge clk) disable iff (any_rst)
    !pend |-> clk_sel == tgt);

  assert_hold_on_write_R9: assert property (@(posedge clk) disable iff (any_rst)
    wr_en |=> $stable(clk_sel));

  assert_hold_in_wait_R9: assert property (@(posedge clk) disable iff (any_rst)
    (pend && cnt != lim - CW'(1)) |=> $stable(clk_sel));

  assert_switch_on_expiry_R5: assert property (@(posedge clk) disable iff (any_rst)
    (pend && !wr_en && cnt == lim - CW'(1)) |=> clk_sel == $past(tgt));

  assert_mult_legal_R4: assert property (@(posedge clk) disable iff (any_rst)
    !(pll_mult[2] && !(pll_mult[1] && !pll_mult[0])));
endmodule

// File: tb/tb_clk_src_ctrl.sv
module tb_clk_src_ctrl;
  localparam int PERIOD = 10;
  localparam int E0 = 2, E1 = 3, E2 = 6, E3 = 4, E3P = 5;

  logic       clk = 1'b0;
  logic       por_n = 1'b0, rst_n = 1'b1, wr_en = 1'b0, mul_msb = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic [2:0] pll_mult;
  logic [1:0] clk_sel;

  int checks = 0, fails = 0;
  string tag = "R1";

  logic [5:2] m_reg;
  logic [1:0] m_lo;
  logic [2:0] m_mul;
  logic [1:0] m_act;
  logic       m_pend, m_por;
  int         m_left;

  clk_src_ctrl #(.EXP_W0(E0), .EXP_W1(E1), .EXP_W2(E2), .EXP_W3(E3), .EXP_W3_POR(E3P)) dut (
    .clk(clk), .por_n(por_n), .rst_n(rst_n), .wr_en(wr_en), .wdata(wdata),
    .mul_msb(mul_msb), .rdata(rdata), .pll_mult(pll_mult), .clk_sel(clk_sel));

  always #(PERIOD/2) clk = ~clk;

  function automatic int f_len(input logic [1:0] w, input logic por);
    case (w)
      2'b00:   return 1 << E0;
      2'b01:   return 1 << E1;
      2'b10:   return 1 << E2;
      default: return por ? (1 << E3P) : (1 << E3);
    endcase
  endfunction

  function automatic logic [1:0] f_tgt(input logic s_n, input logic p_n);
    return !s_n ? 2'b10 : (!p_n ? 2'b01 : 2'b00);
  endfunction

  function automatic logic f_legal(input logic [2:0] c);
    return (c[2] == 1'b0) || (c == 3'b110);
  endfunction

  task automatic model_edge(input logic w, input logic [7:0] d, input logic m,
                            input logic p, input logic r);
    if (!p || !r) begin
      if (!p) m_por = 1'b1; else m_por = 1'b0;
      m_reg = 4'b1111; m_lo = 2'b00; m_mul = 3'b000;
      m_act = 2'b00; m_pend = 1'b0; m_left = 0;
    end else if (w) begin
      m_reg = d[5:2];
      if (f_legal({m, d[1:0]})) begin
        m_mul = {m, d[1:0]}; m_lo = d[1:0];
      end
      m_pend = f_tgt(m_reg[3], m_reg[2]) != m_act;
      m_left = f_len(m_reg[5:4], m_por);
    end else if (m_pend) begin
      m_left--;
      if (m_left == 0) begin
        m_act = f_tgt(m_reg[3], m_reg[2]);
        m_pend = 1'b0;
      end
    end
  endtask

  task automatic chk(input string req, input logic [7:0] act_v, input logic [7:0] exp_v);
    checks++;
    if (act_v !== exp_v) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act_v, exp_v, $time);
    end
  endtask

  task automatic compare();
    logic [7:0] exp_r;
    exp_r = {m_act != 2'b10, m_act != 2'b01, m_reg, m_lo};
    chk({tag, " status R2"}, {6'b0, rdata[7:6]}, {6'b0, exp_r[7:6]});
    chk({tag, " request R3"}, {2'b0, rdata[5:0]}, {2'b0, exp_r[5:0]});
    chk({tag, " select R5"}, {6'b0, clk_sel}, {6'b0, m_act});
    chk({tag, " multiplier R4"}, {5'b0, pll_mult}, {5'b0, m_mul});
  endtask

  task automatic step(input logic w, input logic [7:0] d, input logic m,
                      input logic p, input logic r);
    @(negedge clk);
    wr_en = w; wdata = d; mul_msb = m; por_n = p; rst_n = r;
    @(posedge clk);
    model_edge(w, d, m, p, r);
    #1;
    compare();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 8'h00, 1'b0, 1'b1, 1'b1);
  endtask

  task automatic wr(input logic [7:0] d, input logic m);
    step(1'b1, d, m, 1'b1, 1'b1);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    #(PERIOD * 150000);
    fails++;
    $display("FAIL watchdog: actual running expected finished");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    tag = "R1";
    step(1'b0, 8'h00, 1'b0, 1'b0, 1'b1);
    step(1'b0, 8'h00, 1'b0, 1'b0, 1'b1);
    chk("R1 reset rdata", rdata, 8'hFC);
    chk("R1 reset select", {6'b0, clk_sel}, 8'h00);
    chk("R1 reset multiplier", {5'b0, pll_mult}, 8'h00);
    idle(3);

    tag = "R5";
    wr(8'hC8, 1'b0); idle(6);
    wr(8'hDC, 1'b0); idle(10);
    wr(8'hE4, 1'b0); idle(70);
    chk("R5 sub reached", {6'b0, clk_sel}, 8'h02);

    tag = "R2 R6";
    wr(8'h3C, 1'b0); idle(40);
    chk("R2 status after main", {6'b0, rdata[7:6]}, 8'h03);

    tag = "R6";
    step(1'b0, 8'h00, 1'b0, 1'b1, 1'b0);
    wr(8'hF4, 1'b0); idle(20);
    step(1'b0, 8'h00, 1'b0, 1'b0, 1'b1);
    wr(8'hF4, 1'b0); idle(40);

    tag = "R3";
    wr(8'hFC, 1'b0); idle(40);
    wr(8'hC0, 1'b0); idle(8);
    chk("R3 sub priority", {6'b0, clk_sel}, 8'h02);

    tag = "R4";
    wr(8'hC2, 1'b1); idle(8);
    chk("R4 legal 6x", {5'b0, pll_mult}, 8'h06);
    wr(8'hC3, 1'b1); idle(2);
    chk("R4 illegal kept", {5'b0, pll_mult}, 8'h06);
    wr(8'hC1, 1'b1); idle(2);
    wr(8'hCF, 1'b0); idle(8);

    tag = "R7";
    wr(8'hE8, 1'b0); idle(10);
    wr(8'hC0, 1'b0); idle(8);

    tag = "R8 R9";
    wr(8'hCC, 1'b0); idle(6);
    wr(8'hC8, 1'b0); idle(2);
    wr(8'hCC, 1'b0); idle(12);
    chk("R8 cancel keeps main", {6'b0, clk_sel}, 8'h00);

    tag = "R5 R7 random";
    for (int i = 0; i < 4000; i++) begin
      int dice;
      dice = int'($urandom % 1000);
      if (dice < 2) step(1'b0, 8'h00, 1'b0, 1'b0, 1'b1);
      else if (dice < 4) step(1'b0, 8'h00, 1'b0, 1'b1, 1'b0);
      else if (dice < 40) step(1'b1, 8'($urandom), 1'($urandom), 1'b1, 1'b1);
      else idle(1);
    end

    summary();
    $finish;
  end
endmodule